// File: doc/BRIEF.md
# Sticky Masked Interrupt Aggregator

This block gathers a small set of active-high interrupt request lines into a single active-low interrupt line meant for one host GPIO pin. Every request line owns a sticky pending bit and an enable bit. The pending bit is set by the request level, sampled on the block's own clock after a short synchronizer chain. It stays set until software clears it. The enable bit gates whether that pending bit can pull the shared output low.

Software reaches both registers over a minimal synchronous register bus. A read returns data combinationally in the same cycle as the read strobe. A write to the pending register clears only the bit positions written as zero.

The output is driven from the pending bits together with the synchronized request that each bit is about to capture. A handler therefore sees the line stay low, with no release pulse, when it clears a source whose request is still asserted. The host detects edges and can only see a new falling edge once every enabled source has gone quiet.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every pending bit and every enable bit is 0, and `irqOutN` is 1.
- R2: `irqOutN` is 0 whenever some line i has enable bit i set and either pending bit i set or its synchronized request high. Otherwise it is 1. A request reaches the synchronized stage after `SYNC_STAGES` (default 2) clock edges.
- R3: The enable register, at bus offset 1 with bit i for line i, holds exactly the last value written to it.
- R4: On each clock edge, a pending bit whose synchronized request is high becomes 1. With the default two stages, a request raised between edges reads as pending after the third edge.
- R5: A pending bit whose synchronized request is low keeps its value across clock edges.
- R6: A write to offset 0 clears every pending bit whose data bit is 0, on the write's clock edge.
- R7: Writing 1 to a pending bit position at offset 0 leaves that bit unchanged.
- R8: If a clear and a high synchronized request meet on the same edge, the clear wins. The bit reads 0 for one cycle and 1 after the next edge. If the line is enabled, `irqOutN` stays low throughout, with no high pulse.
- R9: With `busRdEn` high, `busRdData` shows the pending register at offset 0 and the enable register at offset 1 in the same cycle. With `busRdEn` low it reads 0.
- R10: A write to either register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | NUM_SRC | Active-high interrupt request lines, one per source |
| busAddr | input | ADDR_W | Register offset: 0 pending, 1 enable |
| busWrEn | input | 1 | Write strobe, acts on the next rising edge |
| busRdEn | input | 1 | Read strobe, data valid in the same cycle |
| busWrData | input | NUM_SRC | Write data, bit i belongs to line i |
| busRdData | output | NUM_SRC | Read data, zero when no read is strobed |
| irqOutN | output | 1 | Active-low combined interrupt toward the host |

## Verification
Every combination of enable mask and request pattern on three lines is applied. This separates a wrong mask term from a wrong capture and shows that each line is gated only by its own enable bit. After the requests drop, the same patterns show that bits stay sticky. A clear written with the complement of the enable mask then separates bit-selective clearing from a whole-register clear, and checks that the enable register is left untouched. A directed case clears a bit while its request is held high. It watches `irqOutN` for any rising edge and reads the bit as 0 and then 1, which separates clear-priority from set-priority and shows whether the output uses lookahead.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Register offsets; software depends on these positions.
  localparam int PendOfs   = 0;
  localparam int EnableOfs = 1;

  // Strobes from bus decode to the datapath.
  typedef struct packed {
    logic wrPend;
    logic wrEnable;
    logic rdPend;
    logic rdEnable;
  } agg_strobe_t;

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign dOut = dIn;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], dIn};
      end
      assign dOut = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output agg_strobe_t       strobe
);

  localparam logic [ADDR_W-1:0] PendAddr   = ADDR_W'(PendOfs);
  localparam logic [ADDR_W-1:0] EnableAddr = ADDR_W'(EnableOfs);

  logic hitPend;
  logic hitEnable;

  always_comb begin
    hitPend         = (busAddr == PendAddr);
    hitEnable       = (busAddr == EnableAddr);
    strobe.wrPend   = busWrEn && hitPend;
    strobe.wrEnable = busWrEn && hitEnable;
    strobe.rdPend   = busRdEn && hitPend;
    strobe.rdEnable = busRdEn && hitEnable;
  end

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  agg_strobe_t        strobe,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOutN
);

  logic [NUM_SRC-1:0] reqSync;
  logic [NUM_SRC-1:0] pendReg;
  logic [NUM_SRC-1:0] enableReg;
  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] activeVec;

  irq_agg_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (reqIn),
    .dOut (reqSync)
  );

  // Bits written as zero are cleared; a clear beats a same-edge set.
  assign clrMask = strobe.wrPend ? ~wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendReg <= '0;
    else       pendReg <= (pendReg | reqSync) & ~clrMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                enableReg <= '0;
    else if (strobe.wrEnable) enableReg <= wrData;
  end

  // Lookahead on the synchronized request holds the line through a clear.
  assign activeVec = (pendReg | reqSync) & enableReg;
  assign irqOutN   = ~(|activeVec);

  always_comb begin
    rdData = '0;
    if (strobe.rdPend)   rdData = pendReg;
    if (strobe.rdEnable) rdData = enableReg;
  end

  // ---------------- assertions ----------------
  a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pendReg == '0 && enableReg == '0));

  a_r2_enabled_pending_low: assert property (@(posedge clk) disable iff (!rstN)
    (|(pendReg & enableReg)) |-> !irqOutN);

  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    (pendReg == '0 && reqSync == '0) |-> irqOutN);

  a_r3_enable_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEnable |=> (enableReg == $past(wrData)));

  a_r10_enable_kept: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEnable |=> $stable(enableReg));

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bitchk
      a_r4_capture: assert property (@(posedge clk) disable iff (!rstN)
        (reqSync[i] && !clrMask[i]) |=> pendReg[i]);
      a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
        (pendReg[i] && !clrMask[i]) |=> pendReg[i]);
      a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
        clrMask[i] |=> !pendReg[i]);
    end
  endgenerate

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [NUM_SRC-1:0] busWrData,
  output logic [NUM_SRC-1:0] busRdData,
  output logic               irqOutN
);

  agg_strobe_t strobe;

  irq_agg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobe  (strobe)
  );

  irq_agg_datapath #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .reqIn   (reqIn),
    .strobe  (strobe),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .irqOutN (irqOutN)
  );

  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> (busRdData == '0));

endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;

  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] reqIn = '0;
  logic [0:0]   busAddr = '0;
  logic         busWrEn = 1'b0;
  logic         busRdEn = 1'b0;
  logic [N-1:0] busWrData = '0;
  logic [N-1:0] busRdData;
  logic         irqOutN;

  int testCount = 0;
  int failCount = 0;
  logic watch = 1'b0;
  int highPulses = 0;

  always #10 clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData),
    .busRdData(busRdData), .irqOutN(irqOutN)
  );

  always @(posedge irqOutN) if (watch) highPulses++;

  task automatic check(input string req, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic busWrite(input logic a, input logic [N-1:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic a, output logic [N-1:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    busRdEn = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [N-1:0] rd;
    step(3);
    rstN = 1'b1;
    step(1);

    // R1: reset state
    busRead(1'b0, rd); check("R1 pending after reset", rd, 0);
    busRead(1'b1, rd); check("R1 enable after reset", rd, 0);
    check("R1 irqOutN after reset", irqOutN, 1);

    // Sweep every enable mask against every request pattern.
    for (int en = 0; en < 8; en++) begin
      for (int pat = 0; pat < 8; pat++) begin
        busWrite(1'b1, N'(en));
        busWrite(1'b0, '0);
        reqIn = N'(pat);
        step(2);
        check("R2 lookahead low after sync", irqOutN, ((pat & en) != 0) ? 0 : 1);
        step(1);
        busRead(1'b0, rd); check("R4 capture", rd, pat);
        busRead(1'b1, rd); check("R3 enable readback", rd, en);
        reqIn = '0;
        step(3);
        busRead(1'b0, rd); check("R5 sticky", rd, pat);
        check("R2 irqOutN from pending", irqOutN, ((pat & en) != 0) ? 0 : 1);
        busAddr = 1'b0; busRdEn = 1'b0;
        #1 check("R9 idle read zero", busRdData, 0);
        busWrite(1'b0, ~N'(en));
        busRead(1'b0, rd); check("R6 R7 selective clear", rd, pat & ~en & 7);
        busRead(1'b1, rd); check("R10 enable untouched", rd, en);
        check("R2 irqOutN after clear", irqOutN, 1);
      end
    end

    // R10: enable write leaves pending alone.
    busWrite(1'b1, 3'b000);
    busWrite(1'b0, 3'b000);
    reqIn = 3'b101; step(3); reqIn = '0; step(3);
    busWrite(1'b1, 3'b010);
    busRead(1'b0, rd); check("R10 pending untouched by enable write", rd, 5);
    check("R2 masked pending keeps line high", irqOutN, 1);

    // R8: clear while request stays high on an enabled line.
    busWrite(1'b0, 3'b000);
    busWrite(1'b1, 3'b001);
    reqIn = 3'b001;
    step(3);
    check("R8 line low before clear", irqOutN, 0);
    watch = 1'b1;
    busAddr = 1'b0; busWrData = 3'b110; busWrEn = 1'b1;
    @(posedge clk);
    #1 check("R8 line low just after clear edge", irqOutN, 0);
    @(negedge clk);
    busWrEn = 1'b0;
    busRead(1'b0, rd); check("R8 bit reads 0 in clear cycle", rd, 0);
    step(1);
    busRead(1'b0, rd); check("R8 bit sets again", rd, 1);
    check("R8 line still low", irqOutN, 0);
    watch = 1'b0;
    check("R8 no high pulse on line", highPulses, 0);

    // R8 with request dropped: clear then stays clear.
    reqIn = '0; step(3);
    busWrite(1'b0, 3'b000);
    step(1);
    busRead(1'b0, rd); check("R6 cleared stays clear", rd, 0);
    check("R2 line released", irqOutN, 1);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule